// File: doc/BRIEF.md
# Byte ALU with Operand Selection and Bit Masking

This block is the 8-bit arithmetic and logic datapath of a small microcontroller core that executes 12-bit instructions. Each of its two operands comes from its own four-way selector. Both selectors can pick the working register, the file-register read bus or an instruction literal. The A selector has a fourth choice: a one-hot bit mask, inverted or not. The B selector's fourth choice is the constant one. With these choices, single-bit set and clear reuse the OR and AND paths, and increment and decrement reuse the add and subtract paths.

The byte result is combinational and is produced in the same cycle as the inputs. A zero flag and a carry flag are kept in registers. Each flag has its own write enable and changes on the rising clock edge. The rotate operations shift the stored carry into the result, so two rotates in a row link through the carry flag. The instruction decoder that drives the selects, the operation code and the enables lies outside this block.

Top module: `bitmask_alu`

## Requirements
- R1: Operation code 0000 gives A+B, with carry taken from bit 8 of the 9-bit sum. Code 1000 gives A-B, with carry set to 1 when A >= B unsigned (no borrow).
- R2: Operation code 0001 gives A AND B, 0010 gives A OR B and 0011 gives A XOR B.
- R3: Operation code 0100 gives the bitwise complement of A. Code 0111 gives A with its upper and lower nibbles exchanged.
- R4: Operation code 0101 rotates right through carry: the stored carry enters bit 7 and bit 0 becomes the new carry. Code 0110 rotates left through carry: the stored carry enters bit 0 and bit 7 becomes the new carry. The result always uses the carry value held before the clock edge.
- R5: The A select decodes as 00 = working register, 01 = file bus, 10 = literal and 11 = bit mask.
- R6: The B select decodes as 00 = working register, 01 = file bus, 10 = literal and 11 = constant 1. ADD and SUB with B = 1 give increment and decrement, with wrap-around.
- R7: The bit mask has a single 1 at the position given by the bit index, where index 0 is the LSB. When the invert control is 1, every bit of the mask is inverted.
- R8: On a clock edge where the zero-flag enable is 1, the zero flag takes the value (result == 0). When that enable is 0, the zero flag holds.
- R9: The carry flag loads only when the carry enable is 1 and the operation is ADD, SUB or one of the rotates. In every other case it holds.
- R10: Operation codes outside the nine defined ones give a result of 0 and never load the carry flag.
- R11: A synchronous active-high reset clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| work_reg | input | 8 | Working register value |
| file_bus | input | 8 | File-register read data |
| literal | input | 8 | Instruction literal |
| bit_idx | input | 3 | Bit position for the mask |
| a_src | input | 2 | Operand A selector |
| b_src | input | 2 | Operand B selector |
| op | input | 4 | Operation code |
| mask_inv | input | 1 | Inverts the bit mask when 1 |
| z_wr | input | 1 | Zero flag write enable |
| c_wr | input | 1 | Carry flag write enable |
| result | output | 8 | Combinational result |
| z_flag | output | 1 | Registered zero flag |
| c_flag | output | 1 | Registered carry flag |

## Verification
In a rotate, the carry is read into the result and written with a new value in the same cycle. The bench runs several rotate-through-carry operations back to back, with the carry enable held high. The old carry must appear in each combinational result, and the bit shifted out must reach the carry flag only after the edge. The bench also checks that a logic operation with the carry enable high leaves the carry flag unchanged while the zero flag updates.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int OP_W   = 4;
    localparam int SEL_W  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'b0000,
        OP_AND  = 4'b0001,
        OP_OR   = 4'b0010,
        OP_XOR  = 4'b0011,
        OP_COM  = 4'b0100,
        OP_RRC  = 4'b0101,
        OP_RLC  = 4'b0110,
        OP_SWAP = 4'b0111,
        OP_SUB  = 4'b1000
    } alu_op_e;

    typedef enum logic [SEL_W-1:0] {
        ASRC_WORK = 2'b00,
        ASRC_FILE = 2'b01,
        ASRC_LIT  = 2'b10,
        ASRC_MASK = 2'b11
    } a_src_e;

    typedef enum logic [SEL_W-1:0] {
        BSRC_WORK = 2'b00,
        BSRC_FILE = 2'b01,
        BSRC_LIT  = 2'b10,
        BSRC_ONE  = 2'b11
    } b_src_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
        logic              carry_ok;
    } alu_res_t;

    // Nibble exchange for any even width
    function automatic logic [DATA_W-1:0] half_swap(input logic [DATA_W-1:0] v);
        return {v[DATA_W/2-1:0], v[DATA_W-1:DATA_W/2]};
    endfunction

endpackage

// File: rtl/bit_mask_gen.sv
module bit_mask_gen
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    localparam int SEL = $clog2(WIDTH)
) (
    input  logic [SEL-1:0]   idx,
    input  logic             invert,
    output logic [WIDTH-1:0] mask
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign mask[i] = (idx == SEL'(i)) ^ invert;
    end
endmodule

// File: rtl/operand_sel.sv
module operand_sel
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  a_src_e           a_src,
    input  b_src_e           b_src,
    input  logic [WIDTH-1:0] work_reg,
    input  logic [WIDTH-1:0] file_bus,
    input  logic [WIDTH-1:0] literal,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] opnd_a,
    output logic [WIDTH-1:0] opnd_b
);
    always_comb begin
        case (a_src)
            ASRC_WORK: opnd_a = work_reg;
            ASRC_FILE: opnd_a = file_bus;
            ASRC_LIT:  opnd_a = literal;
            default:   opnd_a = mask;
        endcase
    end

    always_comb begin
        case (b_src)
            BSRC_WORK: opnd_b = work_reg;
            BSRC_FILE: opnd_b = file_bus;
            BSRC_LIT:  opnd_b = literal;
            default:   opnd_b = WIDTH'(1);
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_in,
    output alu_res_t         res
);
    logic [WIDTH:0] sum;
    logic [WIDTH:0] diff;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        diff = {1'b0, a} - {1'b0, b};
        res  = '0;
        case (op)
            OP_ADD: begin
                res.value    = sum[WIDTH-1:0];
                res.carry    = sum[WIDTH];
                res.carry_ok = 1'b1;
            end
            OP_SUB: begin
                res.value    = diff[WIDTH-1:0];
                res.carry    = ~diff[WIDTH];
                res.carry_ok = 1'b1;
            end
            OP_AND:  res.value = a & b;
            OP_OR:   res.value = a | b;
            OP_XOR:  res.value = a ^ b;
            OP_COM:  res.value = ~a;
            OP_SWAP: res.value = half_swap(a);
            OP_RRC: begin
                res.value    = {carry_in, a[WIDTH-1:1]};
                res.carry    = a[0];
                res.carry_ok = 1'b1;
            end
            OP_RLC: begin
                res.value    = {a[WIDTH-2:0], carry_in};
                res.carry    = a[WIDTH-1];
                res.carry_ok = 1'b1;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             z_wr,
    input  logic             c_wr,
    input  logic [WIDTH-1:0] result,
    input  logic             carry_new,
    input  logic             carry_ok,
    output logic             z_flag,
    output logic             c_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            z_flag <= 1'b0;
            c_flag <= 1'b0;
        end else begin
            if (z_wr)
                z_flag <= (result == '0);
            if (c_wr && carry_ok)
                c_flag <= carry_new;
        end
    end

    assert_z_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !z_wr |=> $stable(z_flag));

    assert_c_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(c_wr && carry_ok) |=> $stable(c_flag));

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (!z_flag && !c_flag));
endmodule

// File: rtl/bitmask_alu.sv
module bitmask_alu
    import byte_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] work_reg,
    input  logic [DATA_W-1:0] file_bus,
    input  logic [DATA_W-1:0] literal,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [SEL_W-1:0]  a_src,
    input  logic [SEL_W-1:0]  b_src,
    input  logic [OP_W-1:0]   op,
    input  logic              mask_inv,
    input  logic              z_wr,
    input  logic              c_wr,
    output logic [DATA_W-1:0] result,
    output logic              z_flag,
    output logic              c_flag
);
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;
    alu_res_t          core_out;

    bit_mask_gen #(.WIDTH(DATA_W)) u_mask (
        .idx    (bit_idx),
        .invert (mask_inv),
        .mask   (mask)
    );

    operand_sel #(.WIDTH(DATA_W)) u_sel (
        .a_src    (a_src_e'(a_src)),
        .b_src    (b_src_e'(b_src)),
        .work_reg (work_reg),
        .file_bus (file_bus),
        .literal  (literal),
        .mask     (mask),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b)
    );

    alu_core #(.WIDTH(DATA_W)) u_core (
        .op       (alu_op_e'(op)),
        .a        (opnd_a),
        .b        (opnd_b),
        .carry_in (c_flag),
        .res      (core_out)
    );

    flag_reg #(.WIDTH(DATA_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .z_wr      (z_wr),
        .c_wr      (c_wr),
        .result    (core_out.value),
        .carry_new (core_out.carry),
        .carry_ok  (core_out.carry_ok),
        .z_flag    (z_flag),
        .c_flag    (c_flag)
    );

    assign result = core_out.value;

    assert_mask_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        (a_src == ASRC_MASK && !mask_inv) |-> $onehot(opnd_a));

    assert_mask_inv_R7: assert property (@(posedge clk) disable iff (rst)
        (a_src == ASRC_MASK && mask_inv) |-> ($countones(opnd_a) == DATA_W-1));

    assert_rrc_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (c_wr && op == OP_RRC) |=> (c_flag == $past(opnd_a[0])));

    assert_rlc_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (c_wr && op == OP_RLC) |=> (c_flag == $past(opnd_a[DATA_W-1])));

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (op[3] && op[2:0] != 3'b000) |-> (result == '0));
endmodule

// File: tb/bitmask_alu_tb.sv
module bitmask_alu_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] work_reg = '0, file_bus = '0, literal = '0;
    logic [2:0] bit_idx = '0;
    logic [1:0] a_src = '0, b_src = '0;
    logic [3:0] op = '0;
    logic       mask_inv = 1'b0, z_wr = 1'b0, c_wr = 1'b0;
    logic [7:0] result;
    logic       z_flag, c_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bitmask_alu u_dut (
        .clk(clk), .rst(rst), .work_reg(work_reg), .file_bus(file_bus),
        .literal(literal), .bit_idx(bit_idx), .a_src(a_src), .b_src(b_src),
        .op(op), .mask_inv(mask_inv), .z_wr(z_wr), .c_wr(c_wr),
        .result(result), .z_flag(z_flag), .c_flag(c_flag)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation; check result before the edge, flags after it.
    task automatic run(input string tag, input logic [1:0] as, input logic [1:0] bs,
                       input logic [3:0] o, input logic inv, input logic [2:0] idx,
                       input logic [7:0] w, input logic [7:0] f, input logic [7:0] k,
                       input logic zw, input logic cw,
                       input logic [7:0] exp_res, input logic exp_z, input logic exp_c);
        @(negedge clk);
        a_src = as; b_src = bs; op = o; mask_inv = inv; bit_idx = idx;
        work_reg = w; file_bus = f; literal = k; z_wr = zw; c_wr = cw;
        #2;
        check({tag, " result"}, result, exp_res);
        @(posedge clk);
        #2;
        z_wr = 1'b0; c_wr = 1'b0;
        check({tag, " z"}, {7'b0, z_flag}, {7'b0, exp_z});
        check({tag, " c"}, {7'b0, c_flag}, {7'b0, exp_c});
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 reset z", {7'b0, z_flag}, 8'h00);
        check("R11 reset c", {7'b0, c_flag}, 8'h00);
    endtask

    task automatic t_arith();
        run("R1 add carry", 2'b01, 2'b00, 4'b0000, 0, 0, 8'hF0, 8'h20, 0, 1, 1, 8'h10, 0, 1);
        run("R1 sub equal", 2'b01, 2'b00, 4'b1000, 0, 0, 8'h05, 8'h05, 0, 1, 1, 8'h00, 1, 1);
        run("R1 sub borrow", 2'b01, 2'b00, 4'b1000, 0, 0, 8'h05, 8'h03, 0, 1, 1, 8'hFE, 0, 0);
    endtask

    task automatic t_logic();
        run("R2 and", 2'b00, 2'b10, 4'b0001, 0, 0, 8'h3C, 0, 8'h0F, 1, 0, 8'h0C, 0, 0);
        run("R2 or",  2'b00, 2'b10, 4'b0010, 0, 0, 8'h3C, 0, 8'h0F, 1, 0, 8'h3F, 0, 0);
        run("R2 xor", 2'b00, 2'b10, 4'b0011, 0, 0, 8'h3C, 0, 8'h3C, 1, 0, 8'h00, 1, 0);
        run("R3 com lit", 2'b10, 2'b00, 4'b0100, 0, 0, 0, 0, 8'h5A, 1, 0, 8'hA5, 0, 0);
        run("R3 swap file", 2'b01, 2'b00, 4'b0111, 0, 0, 0, 8'h12, 0, 0, 0, 8'h21, 0, 0);
        run("R5 a=work", 2'b00, 2'b01, 4'b0010, 0, 0, 8'h81, 8'h00, 8'h7E, 0, 0, 8'h81, 0, 0);
    endtask

    task automatic t_rotate();
        // set carry first: 0xFF + 1
        run("R6 inc wrap", 2'b01, 2'b11, 4'b0000, 0, 0, 0, 8'hFF, 0, 1, 1, 8'h00, 1, 1);
        run("R4 rrc in", 2'b01, 2'b00, 4'b0101, 0, 0, 0, 8'h01, 0, 0, 1, 8'h80, 1, 1);
        run("R4 rlc in", 2'b01, 2'b00, 4'b0110, 0, 0, 0, 8'h80, 0, 0, 1, 8'h01, 1, 1);
        run("R4 rrc out0", 2'b01, 2'b00, 4'b0101, 0, 0, 0, 8'h02, 0, 0, 1, 8'h81, 1, 0);
        run("R4 rlc old0", 2'b01, 2'b00, 4'b0110, 0, 0, 0, 8'h40, 0, 0, 1, 8'h80, 1, 0);
    endtask

    task automatic t_mask();
        run("R7 set bit3", 2'b11, 2'b01, 4'b0010, 0, 3'd3, 0, 8'h00, 0, 0, 0, 8'h08, 1, 0);
        run("R7 clr bit3", 2'b11, 2'b01, 4'b0001, 1, 3'd3, 0, 8'hFF, 0, 0, 0, 8'hF7, 1, 0);
        run("R7 set bit7", 2'b11, 2'b01, 4'b0010, 0, 3'd7, 0, 8'h00, 0, 0, 0, 8'h80, 1, 0);
        run("R7 set bit0", 2'b11, 2'b01, 4'b0010, 0, 3'd0, 0, 8'h00, 0, 0, 0, 8'h01, 1, 0);
        run("R6 dec wrap", 2'b01, 2'b11, 4'b1000, 0, 0, 0, 8'h00, 0, 1, 1, 8'hFF, 0, 0);
    endtask

    task automatic t_hold();
        run("R8 z hold", 2'b10, 2'b10, 4'b0011, 0, 0, 0, 0, 8'h44, 0, 0, 8'h00, 0, 0);
        run("R1 add set c", 2'b10, 2'b10, 4'b0000, 0, 0, 0, 0, 8'h80, 1, 1, 8'h00, 1, 1);
        run("R9 c hold logic", 2'b10, 2'b10, 4'b0001, 0, 0, 0, 0, 8'h11, 1, 1, 8'h11, 0, 1);
        run("R9 c hold en0", 2'b10, 2'b10, 4'b1000, 0, 0, 0, 0, 8'h01, 0, 0, 8'h00, 0, 1);
        run("R10 unused op", 2'b10, 2'b10, 4'b1001, 0, 0, 0, 0, 8'h77, 1, 1, 8'h00, 1, 1);
        run("R10 unused op2", 2'b10, 2'b10, 4'b1111, 0, 0, 0, 0, 8'h23, 0, 1, 8'h00, 1, 1);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_arith();
        t_logic();
        t_rotate();
        t_mask();
        t_hold();
        t_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule